// File: doc/BRIEF.md
# Byte-to-Word Host Bridge

This block connects a host with an 8-bit data path to a peripheral whose registers are 16 bits wide. Every host access is byte addressed. Address bit 0 picks between the low byte, which starts a real transfer to or from the peripheral, and the high byte, which only touches a staging register inside the bridge. On writes the host stores the upper byte first. The later low-byte write then presents both bytes to the peripheral under a single strobe. On reads the host takes the low byte first. That access fetches the full 16-bit word, returns its low half and keeps the upper half, which a later high-byte read returns.

The upper address bits are compared with a base value before anything is decoded. Inside the selected window of eight bytes, the write decode drives three strobes: two transmit loads for the first and second halves of a word, and a control-register load. The read decode drives two receiver enables, and address bit 1 selects which word of the receiver is read. All strobes are active low and held for a programmable number of clocks. The bridge enables its 16-bit output only while a write strobe is low. It enables its byte output only in the cycle where it acknowledges a read.

Top module: `byte_bridge16`

## Requirements
- R1: After reset, all five strobes are high, both output enables are low, host_ack is low and host_rdata is zero.
- R2: An access whose address bits [7:3] differ from BASE produces no strobe and no acknowledge, and does not change either staging byte.
- R3: A selected write with address bit 0 set stores host_wdata as the upper staging byte, drives no strobe, and raises host_ack in the cycle after the request.
- R4: A selected write with address bit 0 clear drives per_wdata = {upper staging byte, host_wdata}. Offset 0 pulses per_load1_n, offset 2 pulses per_load2_n, and offsets 4 and 6 pulse per_ctrl_n. per_wdata_oe is high exactly while that strobe is low. The upper staging byte stays valid for any number of later low-byte writes.
- R5: A selected read with address bit 0 clear pulses per_rx1_n for offsets 0 and 2 and per_rx2_n for offsets 4 and 6. During the strobe, per_word_sel equals address bit 1. The read returns per_rdata[7:0], sampled on the last strobe cycle, and stores per_rdata[15:8] as the upper read byte.
- R6: A selected read with address bit 0 set drives no strobe, acknowledges in the cycle after the request, and returns the upper byte captured by the most recent low-byte read.
- R7: A strobe stays low for exactly PULSE_CLKS cycles. No more than one strobe is low at any time. host_ack rises in the cycle after the strobe returns high.
- R8: host_rdata_oe is high only in the acknowledge cycle of a read. host_rdata is zero whenever host_rdata_oe is low.
- R9: A request that arrives while an access is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 8 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_wr | input | 1 | Write request, one cycle |
| host_rd | input | 1 | Read request, one cycle |
| host_ack | output | 1 | Access complete, one cycle |
| host_rdata | output | 8 | Read byte, valid while host_rdata_oe |
| host_rdata_oe | output | 1 | Output enable for the host byte bus |
| per_wdata | output | 16 | Word driven to the peripheral |
| per_wdata_oe | output | 1 | Output enable for per_wdata |
| per_rdata | input | 16 | Word returned by the peripheral |
| per_word_sel | output | 1 | Receiver word select |
| per_load1_n | output | 1 | First-half transmit load strobe |
| per_load2_n | output | 1 | Second-half transmit load strobe |
| per_ctrl_n | output | 1 | Control register load strobe |
| per_rx1_n | output | 1 | Receiver 1 read enable |
| per_rx2_n | output | 1 | Receiver 2 read enable |

## Verification
A wrong upper staging byte stays hidden until the next low-byte write or high-byte read. The bench therefore follows every staging update with an access that brings that byte out through the ports, within a few cycles. If the sequencer takes a wrong state, the effect shows in the same access: a strobe of the wrong length, the wrong strobe, a missing or early acknowledge, or an output enable left high. The sweeps cover every offset in both directions, so a decode error appears at the first access to the affected offset.

// File: rtl/bb16_pkg.sv
package bb16_pkg;
  localparam int NUM_STB = 5;

  typedef enum logic [2:0] {
    FN_LOAD1 = 3'd0,
    FN_LOAD2 = 3'd1,
    FN_CTRL  = 3'd2,
    FN_RX1   = 3'd3,
    FN_RX2   = 3'd4
  } fn_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_DONE  = 2'd2
  } st_e;
endpackage

// File: rtl/bb16_decode.sv
module bb16_decode
  import bb16_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BASE   = 31
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_wr,
  output logic              hit,
  output logic              hi_byte,
  output fn_e               fn,
  output logic              word_sel
);
  localparam int TAG_W = ADDR_W - 3;

  always_comb begin
    hit      = (addr[ADDR_W-1:3] == TAG_W'(BASE));
    hi_byte  = addr[0];
    word_sel = addr[1];
    if (is_wr) begin
      case (addr[2:1])
        2'd0:    fn = FN_LOAD1;
        2'd1:    fn = FN_LOAD2;
        default: fn = FN_CTRL;
      endcase
    end else begin
      fn = addr[2] ? FN_RX2 : FN_RX1;
    end
  end
endmodule

// File: rtl/bb16_seq.sv
module bb16_seq
  import bb16_pkg::*;
#(
  parameter int PULSE_CLKS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_wr,
  input  logic               req_rd,
  input  logic               hit,
  input  logic               hi_byte,
  input  fn_e                fn,
  input  logic               word_sel_in,
  output logic [NUM_STB-1:0] stb_q,
  output logic               word_sel_q,
  output logic               wdata_oe_q,
  output logic               ack_q,
  output logic               rdata_oe_q,
  output logic               busy,
  output logic               acc_hi_wr,
  output logic               acc_lo_wr,
  output logic               acc_hi_rd,
  output logic               rd_capture,
  output logic               finish
);
  localparam int CNT_W = $clog2(PULSE_CLKS + 1);

  st_e              st;
  logic [CNT_W-1:0] cnt;
  logic             cur_rd;
  logic             is_wr, is_rd, accept;
  logic [NUM_STB-1:0] stb_d;

  assign is_wr  = req_wr;
  assign is_rd  = req_rd & ~req_wr;
  assign busy   = (st != ST_IDLE);
  assign accept = (st == ST_IDLE) & (is_wr | is_rd) & hit;

  assign acc_hi_wr  = accept & is_wr & hi_byte;
  assign acc_lo_wr  = accept & is_wr & ~hi_byte;
  assign acc_hi_rd  = accept & is_rd & hi_byte;
  assign rd_capture = (st == ST_PULSE) & (cnt == '0) & cur_rd;
  assign finish     = (st == ST_DONE);

  for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
    assign stb_d[g] = (fn == fn_e'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      cur_rd     <= 1'b0;
      stb_q      <= '0;
      word_sel_q <= 1'b0;
      wdata_oe_q <= 1'b0;
      ack_q      <= 1'b0;
      rdata_oe_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept) begin
            cur_rd <= is_rd;
            if (hi_byte) begin
              st         <= ST_DONE;
              ack_q      <= 1'b1;
              rdata_oe_q <= is_rd;
            end else begin
              st         <= ST_PULSE;
              stb_q      <= stb_d;
              cnt        <= CNT_W'(PULSE_CLKS - 1);
              wdata_oe_q <= is_wr;
              word_sel_q <= word_sel_in;
            end
          end
        end
        ST_PULSE: begin
          if (cnt == '0) begin
            st         <= ST_DONE;
            stb_q      <= '0;
            wdata_oe_q <= 1'b0;
            ack_q      <= 1'b1;
            rdata_oe_q <= cur_rd;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          st         <= ST_IDLE;
          ack_q      <= 1'b0;
          rdata_oe_q <= 1'b0;
        end
      endcase
    end
  end

  // strobe length monitor
  logic [CNT_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)         run_q <= '0;
    else if (|stb_q) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  assert_stb_width_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(|stb_q) |-> (run_q == CNT_W'(PULSE_CLKS)));

  assert_ack_after_stb_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(|stb_q) |-> ack_q);

  assert_hi_write_ack_R3: assert property (@(posedge clk) disable iff (rst)
    acc_hi_wr |=> (ack_q && stb_q == '0));

  assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && |stb_q && !rd_capture && !(st == ST_PULSE && cnt == '0)) |=> $stable(stb_q));
endmodule

// File: rtl/bb16_stage.sv
module bb16_stage #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic [2*BYTE_W-1:0] per_rdata,
  input  logic              acc_hi_wr,
  input  logic              acc_lo_wr,
  input  logic              acc_hi_rd,
  input  logic              rd_capture,
  input  logic              finish,
  output logic [2*BYTE_W-1:0] per_wdata,
  output logic [BYTE_W-1:0] rdata_q
);
  logic [BYTE_W-1:0] up_out_q, lo_out_q, up_in_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_out_q <= '0;
      lo_out_q <= '0;
      up_in_q  <= '0;
      rdata_q  <= '0;
    end else begin
      if (acc_hi_wr) up_out_q <= host_wdata;
      if (acc_lo_wr) lo_out_q <= host_wdata;
      if (rd_capture) begin
        up_in_q <= per_rdata[2*BYTE_W-1:BYTE_W];
        rdata_q <= per_rdata[BYTE_W-1:0];
      end else if (acc_hi_rd) begin
        rdata_q <= up_in_q;
      end else if (finish) begin
        rdata_q <= '0;
      end
    end
  end

  assign per_wdata = {up_out_q, lo_out_q};

  assert_hi_read_returns_R6: assert property (@(posedge clk) disable iff (rst)
    acc_hi_rd |=> (rdata_q == $past(up_in_q)));

  assert_up_out_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !acc_hi_wr |=> $stable(up_out_q));
endmodule

// File: rtl/byte_bridge16.sv
module byte_bridge16
  import bb16_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int BASE       = 31,
  parameter int PULSE_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic              host_ack,
  output logic [7:0]        host_rdata,
  output logic              host_rdata_oe,
  output logic [15:0]       per_wdata,
  output logic              per_wdata_oe,
  input  logic [15:0]       per_rdata,
  output logic              per_word_sel,
  output logic              per_load1_n,
  output logic              per_load2_n,
  output logic              per_ctrl_n,
  output logic              per_rx1_n,
  output logic              per_rx2_n
);
  logic               hit, hi_byte, word_sel, busy;
  fn_e                fn;
  logic [NUM_STB-1:0] stb_q;
  logic               acc_hi_wr, acc_lo_wr, acc_hi_rd, rd_capture, finish;

  bb16_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_decode (
    .addr(host_addr), .is_wr(host_wr), .hit(hit), .hi_byte(hi_byte),
    .fn(fn), .word_sel(word_sel)
  );

  bb16_seq #(.PULSE_CLKS(PULSE_CLKS)) u_seq (
    .clk(clk), .rst(rst), .req_wr(host_wr), .req_rd(host_rd), .hit(hit),
    .hi_byte(hi_byte), .fn(fn), .word_sel_in(word_sel), .stb_q(stb_q),
    .word_sel_q(per_word_sel), .wdata_oe_q(per_wdata_oe), .ack_q(host_ack),
    .rdata_oe_q(host_rdata_oe), .busy(busy), .acc_hi_wr(acc_hi_wr),
    .acc_lo_wr(acc_lo_wr), .acc_hi_rd(acc_hi_rd), .rd_capture(rd_capture),
    .finish(finish)
  );

  bb16_stage #(.BYTE_W(8)) u_stage (
    .clk(clk), .rst(rst), .host_wdata(host_wdata), .per_rdata(per_rdata),
    .acc_hi_wr(acc_hi_wr), .acc_lo_wr(acc_lo_wr), .acc_hi_rd(acc_hi_rd),
    .rd_capture(rd_capture), .finish(finish), .per_wdata(per_wdata),
    .rdata_q(host_rdata)
  );

  assign per_load1_n = ~stb_q[FN_LOAD1];
  assign per_load2_n = ~stb_q[FN_LOAD2];
  assign per_ctrl_n  = ~stb_q[FN_CTRL];
  assign per_rx1_n   = ~stb_q[FN_RX1];
  assign per_rx2_n   = ~stb_q[FN_RX2];

  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({per_load1_n, per_load2_n, per_ctrl_n, per_rx1_n, per_rx2_n} ^ 5'b11111));

  assert_rdata_oe_ack_R8: assert property (@(posedge clk) disable iff (rst)
    host_rdata_oe |-> host_ack);

  assert_rdata_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !host_rdata_oe |-> (host_rdata == 8'h00));

  assert_wdata_oe_R4: assert property (@(posedge clk) disable iff (rst)
    per_wdata_oe |-> (!per_load1_n || !per_load2_n || !per_ctrl_n));

  assert_miss_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    ((host_wr || host_rd) && !hit && !busy) |=>
      (per_load1_n && per_load2_n && per_ctrl_n && per_rx1_n && per_rx2_n && !host_ack));
endmodule

// File: tb/byte_bridge16_bench.sv
module byte_bridge16_bench;
  localparam int PERIOD = 10;
  localparam int PULSE  = 3;
  localparam logic [4:0] BASE_TAG = 5'h1F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  host_addr = '0, host_wdata = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic        host_ack, host_rdata_oe, per_wdata_oe, per_word_sel;
  logic [7:0]  host_rdata;
  logic [15:0] per_wdata, per_rdata;
  logic        per_load1_n, per_load2_n, per_ctrl_n, per_rx1_n, per_rx2_n;

  int total = 0;
  int bad   = 0;

  logic [15:0] rxv [4];

  always #(PERIOD/2) clk = ~clk;

  assign per_rdata = !per_rx1_n ? rxv[{1'b0, per_word_sel}] :
                     !per_rx2_n ? rxv[{1'b1, per_word_sel}] : 16'h0000;

  byte_bridge16 #(.ADDR_W(8), .BASE(31), .PULSE_CLKS(PULSE)) u_byte_bridge16 (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_ack(host_ack),
    .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
    .per_wdata(per_wdata), .per_wdata_oe(per_wdata_oe), .per_rdata(per_rdata),
    .per_word_sel(per_word_sel), .per_load1_n(per_load1_n),
    .per_load2_n(per_load2_n), .per_ctrl_n(per_ctrl_n),
    .per_rx1_n(per_rx1_n), .per_rx2_n(per_rx2_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // results of the last access
  int          r_low, r_wait;
  logic [4:0]  r_which;
  logic [15:0] r_wbus;
  logic        r_sel, r_ack, r_rdoe, r_oe_bad, r_rdoe_bad;
  logic [7:0]  r_rdata;

  task automatic access(input bit wr, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = wr; host_rd = !wr;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
    r_low = 0; r_which = '0; r_wbus = '0; r_sel = 1'b0; r_ack = 1'b0;
    r_rdoe = 1'b0; r_oe_bad = 1'b0; r_rdoe_bad = 1'b0; r_rdata = '0; r_wait = 0;
    for (int i = 0; i < 20; i++) begin
      logic [4:0] s;
      s = ~{per_rx2_n, per_rx1_n, per_ctrl_n, per_ld2(), per_load1_n};
      if (|s) begin
        r_low++; r_which |= s; r_wbus = per_wdata; r_sel = per_word_sel;
      end
      if (per_wdata_oe != |s[2:0]) r_oe_bad = 1'b1;
      if (host_ack) begin
        r_ack = 1'b1; r_rdata = host_rdata; r_rdoe = host_rdata_oe; r_wait = i;
        break;
      end
      if (host_rdata_oe || host_rdata != 8'h00) r_rdoe_bad = 1'b1;
      @(negedge clk);
    end
  endtask

  function automatic logic per_ld2();
    return per_load2_n;
  endfunction

  initial begin
    #(PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] up;
    for (int i = 0; i < 4; i++) rxv[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({per_load1_n, per_load2_n, per_ctrl_n, per_rx1_n, per_rx2_n} == 5'b11111,
        "R1 strobes", {per_load1_n, per_load2_n, per_ctrl_n, per_rx1_n, per_rx2_n}, 5'h1F);
    chk(!host_ack && !host_rdata_oe && !per_wdata_oe && host_rdata == 0,
        "R1 enables", {host_ack, host_rdata_oe, per_wdata_oe}, 0);

    // write sweep: offsets 0,2,4,6 with several byte patterns
    for (int k = 0; k < 4; k++) begin
      for (int o = 0; o < 4; o++) begin
        logic [7:0] hb, lb;
        logic [4:0] ew;
        hb = 8'(k * 53 + o * 17 + 1);
        lb = 8'(k * 29 + o * 71 + 3);
        ew = (o == 0) ? 5'b00001 : (o == 1) ? 5'b00010 : 5'b00100;
        access(1'b1, {BASE_TAG, 3'(o * 2 + 1)}, hb);
        chk(r_ack && r_wait == 0 && r_low == 0, "R3 hi write", r_low, 0);
        access(1'b1, {BASE_TAG, 3'(o * 2)}, lb);
        chk(r_which == ew, "R4 strobe select", r_which, ew);
        chk(r_wbus == {hb, lb}, "R4 word", r_wbus, {hb, lb});
        chk(!r_oe_bad, "R4 oe window", r_oe_bad, 0);
        chk(r_low == PULSE && r_ack && r_wait == PULSE, "R7 width", r_low, PULSE);
        chk(!r_rdoe_bad && !r_rdoe, "R8 write no rdata", r_rdoe, 0);
        lb = ~lb;
        access(1'b1, {BASE_TAG, 3'(o * 2)}, lb);
        chk(r_wbus == {hb, lb}, "R4 upper reused", r_wbus, {hb, lb});
      end
    end

    // read sweep
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 4; j++) rxv[j] = 16'((k * 4 + j) * 16'h1357 + 16'h2468);
      for (int j = 0; j < 4; j++) begin
        logic [4:0] er;
        er = (j < 2) ? 5'b01000 : 5'b10000;
        access(1'b0, {BASE_TAG, 3'(j * 2)}, 8'h00);
        chk(r_which == er, "R5 receiver select", r_which, er);
        chk(r_sel == j[0], "R5 word select", r_sel, j[0]);
        chk(r_rdoe && r_rdata == rxv[j][7:0], "R5 low byte", r_rdata, rxv[j][7:0]);
        chk(r_low == PULSE && !r_rdoe_bad, "R7 R8 read strobe", r_low, PULSE);
        access(1'b0, {BASE_TAG, 3'(j * 2 + 1)}, 8'h00);
        chk(r_rdoe && r_low == 0 && r_wait == 0 && r_rdata == rxv[j][15:8],
            "R6 high byte", r_rdata, rxv[j][15:8]);
      end
    end

    // latest low read wins the captured upper byte
    access(1'b0, {BASE_TAG, 3'd0}, 8'h00);
    access(1'b0, {BASE_TAG, 3'd6}, 8'h00);
    access(1'b0, {BASE_TAG, 3'd1}, 8'h00);
    chk(r_rdata == rxv[3][15:8], "R6 latest capture", r_rdata, rxv[3][15:8]);

    // chip-select miss
    access(1'b1, {BASE_TAG, 3'd1}, 8'hA5);
    for (int t = 0; t < 31; t += 5) begin
      access(1'b1, {5'(t), 3'd1}, 8'h3C);
      chk(!r_ack && r_low == 0, "R2 miss hi write", r_ack, 0);
      access(1'b1, {5'(t), 3'd0}, 8'h3C);
      chk(!r_ack && r_low == 0, "R2 miss lo write", r_low, 0);
      access(1'b0, {5'(t), 3'd4}, 8'h00);
      chk(!r_ack && r_low == 0 && !r_rdoe_bad, "R2 miss read", r_low, 0);
    end
    access(1'b1, {BASE_TAG, 3'd2}, 8'h11);
    chk(r_wbus == 16'hA511, "R2 upper unchanged", r_wbus, 16'hA511);

    // request during a busy access
    @(negedge clk);
    host_addr = {BASE_TAG, 3'd0}; host_wdata = 8'h22; host_wr = 1'b1;
    @(negedge clk);
    host_addr = {BASE_TAG, 3'd1}; host_wdata = 8'h77;
    @(negedge clk);
    host_wr = 1'b0;
    repeat (PULSE + 4) @(negedge clk);
    access(1'b1, {BASE_TAG, 3'd4}, 8'h33);
    up = r_wbus[15:8];
    chk(up == 8'hA5 && r_which == 5'b00100, "R9 busy ignored", up, 8'hA5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule